// File: doc/BRIEF.md
# Timer Waveform Generator with PWM

An 8-bit timer/counter with a waveform generator. A prescaler turns the I/O clock into timer ticks at one of seven division ratios, or holds the timer still. Every tick, the counter moves one step in the counting scheme that the waveform-mode select picks: free running over the full 8-bit range, clear-on-compare against compare register A, or single-slope fast PWM with its top set either to 0xFF or to compare register A. A compare unit watches the count against both compare registers. It drives one waveform output and raises sticky flags for a match on A, a match on B, and counter overflow. The waveform reaches the pin only when the direction input selects output.

The timing is built around a small state machine whose state register follows the clock and mode selects. The states are IDLE (clock select 0, no counting), NORMAL (free running), CTC (top is compare A, written through directly), PWM_FULL (fast PWM, top 0xFF) and PWM_A (fast PWM, top is buffered compare A). Every clock edge takes the transition that the inputs ask for. Any state goes to IDLE when the clock select is 0. Otherwise wave mode 2 leads to CTC, 3 to PWM_FULL, 7 to PWM_A, and any other code to NORMAL. The state therefore follows a select change one clock later. In the PWM states the compare values are held in shadow registers, which reload when the counter leaves TOP. In all other states the compare inputs act directly.

Top module: `wavetimer`

## Requirements
- R1: While reset is asserted, the count is 0, all three flags are 0, and both the waveform and the pin output are 0.
- R2: Clock select codes 1 to 7 give tick periods of 1, 8, 32, 64, 128, 256 and 1024 clocks, and the counter steps once per tick. Code 0 stops the counter.
- R3: A change of clock select restarts the prescaler. The clock edge that first sees the new code gives no tick, and the first tick comes N edges after that edge.
- R4: For wave-mode codes other than 2, 3 and 7, the counter runs from 0 to 0xFF and then wraps to 0.
- R5: In CTC mode (wave mode 2), the tick that finds the count equal to compare A sets the count to 0.
- R6: In CTC mode, compare A acts unbuffered. If it is lowered below the current count, the counter keeps counting up to 0xFF, wraps to 0 (which sets the overflow flag), and clears only at the next equality.
- R7: With output mode 1, the waveform toggles on every A match. In CTC mode this gives one toggle every N·(1+A) clocks.
- R8: Fast PWM counts from 0 up to TOP and then back to 0. TOP is 0xFF in wave mode 3 and buffered compare A in wave mode 7.
- R9: In fast PWM, output mode 2 sets the waveform when the count returns to 0 and clears it on an A match. Output mode 3 does the opposite. If the match falls on TOP, the action at the return to 0 wins.
- R10: In fast PWM, a new compare value takes effect only after the tick at which the counter leaves TOP.
- R11: The A-match and B-match flags are set by the tick that finds the count equal to the compare value. The overflow flag is set by the tick that moves the count from 0xFF to 0. A flag stays set until its clear strobe arrives, and a set in the same cycle as a clear wins.
- R12: pin_oe equals pin_dir. pin_out equals the waveform when pin_dir is 1, and is 0 otherwise.
- R13: Outside fast PWM, output mode 2 clears the waveform on an A match and output mode 3 sets it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | I/O clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_sel | input | 3 | Prescaler select: 0 stop, 1..7 divide by 1/8/32/64/128/256/1024 |
| wave_mode | input | 3 | Waveform mode: 2 CTC, 3 fast PWM top 0xFF, 7 fast PWM top A, others free run |
| out_mode | input | 2 | Output mode: 0 off, 1 toggle, 2 clear/non-inverting, 3 set/inverting |
| cmp_a | input | 8 | Compare value A |
| cmp_b | input | 8 | Compare value B |
| pin_dir | input | 1 | Pin direction, 1 = output |
| clr_a | input | 1 | Clear strobe for the A-match flag |
| clr_b | input | 1 | Clear strobe for the B-match flag |
| clr_ovf | input | 1 | Clear strobe for the overflow flag |
| count | output | 8 | Current counter value |
| oc_wave | output | 1 | Internal waveform before pin gating |
| pin_out | output | 1 | Waveform as gated onto the pin |
| pin_oe | output | 1 | Pin output enable |
| flag_a | output | 1 | Sticky A-match flag |
| flag_b | output | 1 | Sticky B-match flag |
| flag_ovf | output | 1 | Sticky overflow flag |

## Verification
The bench lowers compare A below the running count in CTC mode. A design that buffered the value, or compared with greater-or-equal, would clear early instead of running through 0xFF and raising overflow. It rewrites compare A in the middle of a period in PWM_A, where reloading TOP at once would cut the current period short. It also places the match on TOP, where a design that let the clear-on-match win would hold the output low. Further checks count clock edges across clock-select changes to catch a prescaler that keeps its old phase or ticks on the change edge, and hold a clear strobe across a match to catch a clear that wins over a set.

// File: rtl/wavetimer_pkg.sv
package wavetimer_pkg;

    localparam int SEL_W  = 3;
    localparam int MODE_W = 3;
    localparam int DIV_W  = 11;

    localparam logic [MODE_W-1:0] WM_CTC      = 3'd2;
    localparam logic [MODE_W-1:0] WM_PWM_FULL = 3'd3;
    localparam logic [MODE_W-1:0] WM_PWM_A    = 3'd7;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_NORMAL,
        ST_CTC,
        ST_PWM_FULL,
        ST_PWM_A
    } tmr_state_t;

    typedef enum logic [1:0] {
        OM_OFF,
        OM_TOGGLE,
        OM_CLEAR,
        OM_SET
    } out_mode_t;

    // Division ratio for a clock select code (code 0 is handled as stop).
    function automatic logic [DIV_W-1:0] div_factor(input logic [SEL_W-1:0] sel);
        logic [DIV_W-1:0] n;
        case (sel)
            3'd2:    n = 11'd8;
            3'd3:    n = 11'd32;
            3'd4:    n = 11'd64;
            3'd5:    n = 11'd128;
            3'd6:    n = 11'd256;
            3'd7:    n = 11'd1024;
            default: n = 11'd1;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/wt_prescaler.sv
module wt_prescaler
    import wavetimer_pkg::*;
#(
    parameter int CNT_W = DIV_W - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);

    logic [SEL_W-1:0] sel_q;
    logic [CNT_W-1:0] pre_q;
    logic [DIV_W-1:0] limit;
    logic             sel_moved;

    always_comb begin
        limit     = div_factor(sel) - DIV_W'(1);
        sel_moved = (sel != sel_q);
        tick      = (sel != '0) && !sel_moved && (DIV_W'(pre_q) == limit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= '0;
            pre_q <= '0;
        end else begin
            sel_q <= sel;
            if (sel_moved || tick) begin
                pre_q <= '0;
            end else if (sel != '0) begin
                pre_q <= pre_q + CNT_W'(1);
            end
        end
    end

    // R2: any ratio above 1 leaves at least one clock between ticks
    assert_tick_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (sel != 3'd1)) |=> !tick);

endmodule

// File: rtl/wt_core.sv
module wt_core
    import wavetimer_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [SEL_W-1:0]  clk_sel,
    input  logic [MODE_W-1:0] wave_mode,
    input  logic [CW-1:0]     cmp_a,
    input  logic [CW-1:0]     cmp_b,
    output logic              pwm,
    output logic [CW-1:0]     count,
    output logic              hit_a,
    output logic              hit_b,
    output logic              wrap,
    output logic              bottom
);

    localparam logic [CW-1:0] CNT_MAX = '1;

    tmr_state_t    state_q, state_d;
    logic [CW-1:0] count_q;
    logic [CW-1:0] buf_a_q, buf_b_q;
    logic [CW-1:0] act_a, act_b, top;
    logic          run_en, run, at_top;

    // next-state selection
    always_comb begin
        if (clk_sel == '0) begin
            state_d = ST_IDLE;
        end else begin
            unique case (wave_mode)
                WM_CTC:      state_d = ST_CTC;
                WM_PWM_FULL: state_d = ST_PWM_FULL;
                WM_PWM_A:    state_d = ST_PWM_A;
                default:     state_d = ST_NORMAL;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // per-state outputs
    always_comb begin
        pwm    = 1'b0;
        run_en = 1'b1;
        top    = CNT_MAX;
        unique case (state_q)
            ST_IDLE:     run_en = 1'b0;
            ST_NORMAL:   ;
            ST_CTC:      top = cmp_a;
            ST_PWM_FULL: pwm = 1'b1;
            ST_PWM_A: begin
                pwm = 1'b1;
                top = buf_a_q;
            end
            default:     run_en = 1'b0;
        endcase
    end

    assign act_a  = pwm ? buf_a_q : cmp_a;
    assign act_b  = pwm ? buf_b_q : cmp_b;
    assign run    = tick && run_en;
    assign at_top = (count_q == top);
    assign hit_a  = run && (count_q == act_a);
    assign hit_b  = run && (count_q == act_b);
    assign wrap   = run && (count_q == CNT_MAX);
    assign bottom = run && at_top;
    assign count  = count_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (run) begin
            count_q <= at_top ? '0 : count_q + CW'(1);
        end
    end

    // shadow compare registers: follow the inputs outside PWM, reload at TOP inside
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_a_q <= '0;
            buf_b_q <= '0;
        end else if (!pwm || bottom) begin
            buf_a_q <= cmp_a;
            buf_b_q <= cmp_b;
        end
    end

    // R2: without a tick the count holds
    assert_hold_no_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(count_q));

    // R10: inside PWM the active compare changes only after leaving TOP
    assert_shadow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm && $past(pwm) && !$past(bottom)) |-> (buf_a_q == $past(buf_a_q)));

endmodule

// File: rtl/wt_outunit.sv
module wt_outunit
    import wavetimer_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    out_mode,
    input  logic          pwm,
    input  logic          hit_a,
    input  logic          bottom,
    input  logic [CW-1:0] count,
    output logic          oc
);

    out_mode_t om;
    logic      oc_q, oc_d;

    assign om = out_mode_t'(out_mode);

    always_comb begin
        oc_d = oc_q;
        unique case (om)
            OM_OFF:    ;
            OM_TOGGLE: if (hit_a) oc_d = ~oc_q;
            OM_CLEAR: begin
                if (pwm && bottom) oc_d = 1'b1;
                else if (hit_a)    oc_d = 1'b0;
            end
            OM_SET: begin
                if (pwm && bottom) oc_d = 1'b0;
                else if (hit_a)    oc_d = 1'b1;
            end
            default:   ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) oc_q <= 1'b0;
        else        oc_q <= oc_d;
    end

    assign oc = oc_q;

    // R9: non-inverting PWM output only rises as the count returns to 0
    assert_pwm_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(oc_q) && pwm && $past(pwm) && (om == OM_CLEAR) && ($past(om) == OM_CLEAR))
            |-> (count == '0));

    // R7: a match in toggle mode always flips the output
    assert_toggle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((om == OM_TOGGLE) && ($past(om) == OM_TOGGLE) && $past(hit_a))
            |-> (oc_q != $past(oc_q)));

endmodule

// File: rtl/wavetimer.sv
module wavetimer
    import wavetimer_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEL_W-1:0]  clk_sel,
    input  logic [MODE_W-1:0] wave_mode,
    input  logic [1:0]        out_mode,
    input  logic [CW-1:0]     cmp_a,
    input  logic [CW-1:0]     cmp_b,
    input  logic              pin_dir,
    input  logic              clr_a,
    input  logic              clr_b,
    input  logic              clr_ovf,
    output logic [CW-1:0]     count,
    output logic              oc_wave,
    output logic              pin_out,
    output logic              pin_oe,
    output logic              flag_a,
    output logic              flag_b,
    output logic              flag_ovf
);

    localparam int            NFLAG   = 3;
    localparam logic [CW-1:0] CNT_MAX = '1;

    logic tick, pwm, hit_a, hit_b, wrap, bottom;
    logic [NFLAG-1:0] flag_set, flag_clr, flag_q;

    wt_prescaler u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (clk_sel),
        .tick  (tick)
    );

    wt_core #(.CW(CW)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .clk_sel   (clk_sel),
        .wave_mode (wave_mode),
        .cmp_a     (cmp_a),
        .cmp_b     (cmp_b),
        .pwm       (pwm),
        .count     (count),
        .hit_a     (hit_a),
        .hit_b     (hit_b),
        .wrap      (wrap),
        .bottom    (bottom)
    );

    wt_outunit #(.CW(CW)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .out_mode (out_mode),
        .pwm      (pwm),
        .hit_a    (hit_a),
        .bottom   (bottom),
        .count    (count),
        .oc       (oc_wave)
    );

    assign flag_set = {wrap, hit_b, hit_a};
    assign flag_clr = {clr_ovf, clr_b, clr_a};

    for (genvar g = 0; g < NFLAG; g++) begin : g_flag
        logic bit_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)               bit_q <= 1'b0;
            else if (flag_set[g])     bit_q <= 1'b1;
            else if (flag_clr[g])     bit_q <= 1'b0;
        end
        assign flag_q[g] = bit_q;

        // R11: set beats a simultaneous clear
        assert_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_set[g] && flag_clr[g]) |=> flag_q[g]);

        // R11: a flag without a clear strobe stays set
        assert_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_q[g] && !flag_clr[g]) |=> flag_q[g]);
    end

    assign flag_a   = flag_q[0];
    assign flag_b   = flag_q[1];
    assign flag_ovf = flag_q[2];

    assign pin_oe  = pin_dir;
    assign pin_out = pin_dir & oc_wave;

    // R11: overflow only appears after the count sat at its maximum
    assert_ovf_source_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_ovf) |-> ($past(count) == CNT_MAX));

endmodule

// File: tb/wavetimer_test.sv
module wavetimer_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] clk_sel = '0;
    logic [2:0] wave_mode = '0;
    logic [1:0] out_mode = '0;
    logic [7:0] cmp_a = '0;
    logic [7:0] cmp_b = '0;
    logic       pin_dir = 1'b0;
    logic       clr_a = 1'b0;
    logic       clr_b = 1'b0;
    logic       clr_ovf = 1'b0;
    logic [7:0] count;
    logic       oc_wave, pin_out, pin_oe, flag_a, flag_b, flag_ovf;

    int  n_checks = 0;
    int  n_bad = 0;
    bit  done = 1'b0;

    always #10 clk = ~clk;

    wavetimer uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .clk_sel   (clk_sel),
        .wave_mode (wave_mode),
        .out_mode  (out_mode),
        .cmp_a     (cmp_a),
        .cmp_b     (cmp_b),
        .pin_dir   (pin_dir),
        .clr_a     (clr_a),
        .clr_b     (clr_b),
        .clr_ovf   (clr_ovf),
        .count     (count),
        .oc_wave   (oc_wave),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe),
        .flag_a    (flag_a),
        .flag_b    (flag_b),
        .flag_ovf  (flag_ovf)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // advance n rising edges, landing mid-cycle
    task automatic step(input int n);
        repeat (n) begin
            @(posedge clk);
            #5;
        end
    endtask

    task automatic wait_count(input string req, input int v, input int lim);
        int k = 0;
        while (int'(count) != v && k < lim) begin
            step(1);
            k++;
        end
        chk(req, int'(count), v);
    endtask

    task automatic restart(input int sel, input int wm, input int om,
                           input int a, input int b, input bit dir);
        clk_sel   = 3'(sel);
        wave_mode = 3'(wm);
        out_mode  = 2'(om);
        cmp_a     = 8'(a);
        cmp_b     = 8'(b);
        pin_dir   = dir;
        clr_a = 1'b0; clr_b = 1'b0; clr_ovf = 1'b0;
        rst_n = 1'b0;
        step(2);
        rst_n = 1'b1;
    endtask

    task automatic t_reset_and_prescale;
        restart(1, 0, 0, 0, 0, 1'b1);
        rst_n = 1'b0;
        #1;
        chk("R1 count", int'(count), 0);
        chk("R1 flags", int'({flag_a, flag_b, flag_ovf}), 0);
        chk("R1 wave", int'(oc_wave), 0);
        chk("R1 pin", int'(pin_out), 0);
        chk("R12 oe", int'(pin_oe), 1);
        step(1);
        rst_n = 1'b1;
        step(10);
        chk("R2 div1 count", int'(count), 9);
        clk_sel = 3'd2;
        step(8);
        chk("R3 no early tick", int'(count), 9);
        step(1);
        chk("R3 first tick div8", int'(count), 10);
        step(8);
        chk("R2 div8 period", int'(count), 11);
        clk_sel = 3'd7;
        step(1024);
        chk("R2 div1024 wait", int'(count), 11);
        step(1);
        chk("R2 div1024 tick", int'(count), 12);
        clk_sel = 3'd0;
        step(50);
        chk("R2 stopped", int'(count), 12);
    endtask

    task automatic t_normal_wrap;
        restart(1, 5, 0, 0, 0, 1'b1);
        wait_count("R4 reach max", 255, 300);
        chk("R4 no ovf yet", int'(flag_ovf), 0);
        step(1);
        chk("R4 wrap", int'(count), 0);
        chk("R11 ovf set", int'(flag_ovf), 1);
    endtask

    task automatic t_ctc_toggle_flags;
        int toggles = 0;
        int mx = 0;
        bit prev;
        restart(1, 2, 1, 3, 2, 1'b1);
        wait_count("R5 climb", 3, 10);
        step(1);
        chk("R5 clear", int'(count), 0);
        chk("R7 first toggle", int'(oc_wave), 1);
        chk("R11 flag a", int'(flag_a), 1);
        chk("R11 flag b", int'(flag_b), 1);
        prev = oc_wave;
        for (int i = 0; i < 40; i++) begin
            step(1);
            if (oc_wave != prev) toggles++;
            prev = oc_wave;
            if (int'(count) > mx) mx = int'(count);
        end
        chk("R7 toggle count", toggles, 10);
        chk("R5 max count", mx, 3);
        chk("R11 flag held", int'(flag_a), 1);
        clr_a = 1'b1;
        step(1);
        clr_a = 1'b0;
        chk("R11 cleared", int'(flag_a), 0);
        wait_count("R11 align", 2, 10);
        clr_a = 1'b1;
        step(1);
        chk("R11 clear no hit", int'(flag_a), 0);
        step(1);
        clr_a = 1'b0;
        chk("R11 set wins", int'(flag_a), 1);
        chk("R5 clear again", int'(count), 0);
        // R13: set then clear on match outside PWM
        out_mode = 2'd3;
        wait_count("R13 align set", 3, 10);
        step(1);
        chk("R13 set on match", int'(oc_wave), 1);
        chk("R12 pin follows", int'(pin_out), 1);
        out_mode = 2'd2;
        wait_count("R13 align clear", 3, 10);
        step(1);
        chk("R13 clear on match", int'(oc_wave), 0);
    endtask

    task automatic t_ctc_miss;
        restart(1, 2, 0, 200, 0, 1'b1);
        wait_count("R6 climb", 150, 200);
        cmp_a = 8'd100;
        step(10);
        chk("R6 no early clear", int'(count), 160);
        chk("R6 no ovf yet", int'(flag_ovf), 0);
        wait_count("R6 reach max", 255, 200);
        step(1);
        chk("R6 wrap", int'(count), 0);
        chk("R6 ovf", int'(flag_ovf), 1);
        chk("R6 no match yet", int'(flag_a), 0);
        wait_count("R6 new compare", 100, 200);
        step(1);
        chk("R6 clear at new value", int'(count), 0);
        chk("R6 match flag", int'(flag_a), 1);
    endtask

    task automatic t_pwm_full;
        int high = 0;
        int mx = 0;
        restart(1, 3, 2, 64, 0, 1'b1);
        wait_count("R8 first max", 255, 300);
        step(1);
        for (int i = 0; i < 256; i++) begin
            if (oc_wave) high++;
            if (int'(count) > mx) mx = int'(count);
            step(1);
        end
        chk("R9 non-inverting high", high, 65);
        chk("R8 top 0xFF", mx, 255);
        out_mode = 2'd3;
        wait_count("R9 align", 255, 300);
        step(1);
        high = 0;
        for (int i = 0; i < 256; i++) begin
            if (oc_wave) high++;
            step(1);
        end
        chk("R9 inverting high", high, 191);
    endtask

    task automatic t_pwm_a_buffer;
        restart(1, 7, 2, 20, 0, 1'b1);
        wait_count("R10 align", 5, 30);
        cmp_a = 8'd10;
        wait_count("R10 old top kept", 15, 30);
        wait_count("R8 reach top", 20, 30);
        step(1);
        chk("R8 restart after A", int'(count), 0);
        wait_count("R10 new top", 10, 30);
        step(1);
        chk("R10 new top active", int'(count), 0);
        chk("R9 bottom wins", int'(oc_wave), 1);
        pin_dir = 1'b0;
        step(1);
        chk("R12 pin gated", int'(pin_out), 0);
        chk("R12 oe low", int'(pin_oe), 0);
        pin_dir = 1'b1;
        step(1);
        chk("R12 pin open", int'(pin_out), 1);
    endtask

    initial begin
        t_reset_and_prescale();
        t_normal_wrap();
        t_ctc_toggle_flags();
        t_ctc_miss();
        t_pwm_full();
        t_pwm_a_buffer();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

    initial begin
        #4000000;
        if (!done) begin
            n_checks++;
            n_bad++;
            $display("FAIL watchdog R1-R13 run: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", n_checks, n_bad);
            $finish;
        end
    end

endmodule